// File: doc/BRIEF.md
# Serial Bus Transmit Opcode Sequencer

This block is the control state machine that turns software-written transmit opcodes into an ordered stream of symbol commands for a variable-pulse-width serial bus transmitter. Software writes a 3-bit opcode, a 4-bit expected length and a data byte in one strobe. The sequencer decides what goes out and when: a start-of-frame symbol, data bytes, a CRC, an inverted CRC, a break, or an in-frame response. Each step is handed to the symbol transmitter as one command. The command stays presented until the transmitter acknowledges it.

An in-frame response does not start when it is written. It is held until the receive side reports the end-of-data symbol. It is then released or rejected by comparing the received byte count with the written length, or by the CRC and error status when the length is zero. Some opcode orders are illegal: a message byte on top of an open type-3 response, or a tenth byte in a limited-length frame. These end the frame with an inverted CRC and raise an abort flag and an underflow flag. Both flags are sticky. Software clears them by writing 1.

Symbol timing, arbitration detection, CRC arithmetic and reception are handled outside this block. They reach the block only as the status inputs `bus_idle`, `eod_seen`, `crc_ok`, `rx_err`, `arb_lost` and `rx_count`.

Top module: `vpw_txop_seq`

## Requirements
- R1: Opcode codes are 000 cancel, 001 break, 010 message byte, 011 message byte plus CRC, 100 response type 1, 101 response type 2, 110 response type 3 and 111 response type 3 plus CRC. `cmd_type` codes are 0 SOF, 1 BYTE, 2 CRC, 3 INV_CRC, 4 BREAK and 5 IFR. A break opcode issues one BREAK command. A cancel written while idle issues nothing.
- R2: After reset, no command is issued and both flags are 0. A command holds `cmd_valid`, `cmd_type` and `cmd_data` stable until `cmd_done`. When the next command of a sequence follows, it is presented in the cycle after the acknowledge.
- R3: A message opcode written outside a frame waits for `bus_idle`, then issues SOF followed by BYTE carrying the data. Plain message leaves the frame open. Message plus CRC follows the byte with CRC and ends the frame.
- R4: A message opcode written while a frame is open is sent as BYTE with no SOF. The length field is ignored for message opcodes.
- R5: A response opcode with a non-zero length waits for `eod_seen`. If `rx_count` equals the length, an IFR command carrying the data is issued. Otherwise the abort flag is set and no command is issued.
- R6: With `len_unlimited` at 0, lengths 12 to 15 always abort at end-of-data. With `len_unlimited` at 1, lengths up to 15 are compared normally.
- R7: A length of 0 skips the comparison. The response is sent only when `crc_ok` is 1 and `rx_err` is 0; otherwise the abort flag is set.
- R8: Response types 1 and 2 end after their IFR command. Type 3 plus CRC issues CRC after IFR. Type 3 leaves the frame open, and further type-3 opcodes are then sent as BYTE commands; type 3 plus CRC closes the frame with CRC.
- R9: A message opcode written while a plain type-3 response is open sets both flags and discards the message. INV_CRC is issued after the command in flight, and the frame then ends.
- R10: With `len_unlimited` at 0 and `rx_count` equal to 10, a plain message opcode written inside a frame has the same effect as in R9. With `len_unlimited` at 1 it is sent normally.
- R11: After such an underflow ending, the next message opcode starts a new frame with SOF.
- R12: `arb_lost` during a frame withdraws the command in the next cycle. No command follows until `bus_idle`. A message written meanwhile is then sent as a new frame with SOF.
- R13: Cancel clears any pending opcode. During a frame, the sequencer returns to idle after the command in flight, so no CRC or next byte follows.
- R14: `abort_flag` and `underflow_flag` stay set until `flag_clr` bit 0 or bit 1, respectively, is written with 1. If a set and a clear occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_wr | input | 1 | Opcode write strobe |
| op_code | input | 3 | Transmit opcode |
| op_len | input | 4 | Expected received byte count for responses |
| op_data | input | 8 | Data byte for the opcode |
| len_unlimited | input | 1 | 1 lifts the frame length limit |
| flag_clr | input | 2 | Write-1-to-clear: bit 0 abort, bit 1 underflow |
| bus_idle | input | 1 | Bus is idle |
| eod_seen | input | 1 | One-cycle pulse at a received end-of-data symbol |
| crc_ok | input | 1 | Received frame CRC is correct |
| rx_err | input | 1 | Framing, bit or break error in the received frame |
| arb_lost | input | 1 | Arbitration lost |
| rx_count | input | 4 | Bytes received in the current frame |
| cmd_valid | output | 1 | Command presented to the symbol transmitter |
| cmd_type | output | 3 | Command code |
| cmd_data | output | 8 | Byte for BYTE and IFR commands, else 0 |
| cmd_done | input | 1 | Transmitter has completed the command |
| abort_flag | output | 1 | Transmit request aborted, sticky |
| underflow_flag | output | 1 | Transmit data underflow, sticky |

## Verification
A wrong frame state shows at the ports within one acknowledge. If the block wrongly believes a frame is open, a new message goes out as BYTE where SOF was required, or the reverse. If it misses a pending inverted CRC, the cycle after the acknowledge carries CRC, BYTE or nothing instead of INV_CRC. A bad length gate shows in the cycle after the end-of-data pulse: either an IFR command appears when the abort flag should have risen, or the reverse. The bench therefore checks the command type and data at every acknowledge, and checks the flags one cycle after each triggering write or pulse.

// File: rtl/vpw_txop_pkg.sv
package vpw_txop_pkg;

  typedef enum logic [2:0] {
    OP_CANCEL   = 3'd0,
    OP_BREAK    = 3'd1,
    OP_MSG      = 3'd2,
    OP_MSG_CRC  = 3'd3,
    OP_IFR1     = 3'd4,
    OP_IFR2     = 3'd5,
    OP_IFR3     = 3'd6,
    OP_IFR3_CRC = 3'd7
  } txop_e;

  typedef enum logic [2:0] {
    CMD_SOF     = 3'd0,
    CMD_BYTE    = 3'd1,
    CMD_CRC     = 3'd2,
    CMD_INV_CRC = 3'd3,
    CMD_BREAK   = 3'd4,
    CMD_IFR     = 3'd5
  } cmd_e;

  function automatic logic is_msg(input logic [2:0] op);
    return (op == OP_MSG) || (op == OP_MSG_CRC);
  endfunction

  function automatic logic is_resp(input logic [2:0] op);
    return op[2];
  endfunction

  function automatic logic is_type3(input logic [2:0] op);
    return op[2:1] == 2'b11;
  endfunction

  function automatic logic ends_with_crc(input logic [2:0] op);
    return (op == OP_MSG_CRC) || (op == OP_IFR3_CRC);
  endfunction

endpackage

// File: rtl/vpw_txop_pend.sv
module vpw_txop_pend #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [2:0]        load_op,
  input  logic [LEN_W-1:0]  load_len,
  input  logic [DATA_W-1:0] load_data,
  input  logic              drop,
  output logic              valid,
  output logic [2:0]        op,
  output logic [LEN_W-1:0]  len,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      op    <= '0;
      len   <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      op    <= load_op;
      len   <= load_len;
      data  <= load_data;
    end else if (drop) begin
      valid <= 1'b0;
    end
  end

  AST_PEND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid && (op == $past(load_op))); // R4
endmodule

// File: rtl/vpw_txop_ifr_gate.sv
module vpw_txop_ifr_gate #(
  parameter int LEN_W       = 4,
  parameter int CNT_W       = 4,
  parameter int LIMITED_MAX = 11
) (
  input  logic [LEN_W-1:0] len,
  input  logic             len_unlimited,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             crc_ok,
  input  logic             rx_err,
  output logic             go
);
  function automatic logic gate_fn(input logic [LEN_W-1:0] l, input logic unl,
                                   input logic [CNT_W-1:0] cnt, input logic c_ok,
                                   input logic r_err);
    if (l == '0) return c_ok && !r_err;
    if (!unl && (int'(l) > LIMITED_MAX)) return 1'b0;
    return int'(l) == int'(cnt);
  endfunction

  assign go = gate_fn(len, len_unlimited, rx_count, crc_ok, rx_err);

  always_comb begin
    AST_LIMIT_REJECT: assert (!(go && !len_unlimited && (int'(len) > LIMITED_MAX))); // R6
  end
endmodule

// File: rtl/vpw_txop_flags.sv
module vpw_txop_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)      q <= 1'b0;
      else if (set[i]) q <= 1'b1;
      else if (clr[i]) q <= 1'b0;
    end
    assign flag[i] = q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag[i] && !clr[i] |=> flag[i]); // R14
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] && !set[i] |=> !flag[i]); // R14
  end
endmodule

// File: rtl/vpw_txop_seq.sv
module vpw_txop_seq
  import vpw_txop_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 4,
  parameter int CNT_W       = 4,
  parameter int LIMITED_MAX = 11,
  parameter int UF_COUNT    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_wr,
  input  logic [2:0]        op_code,
  input  logic [LEN_W-1:0]  op_len,
  input  logic [DATA_W-1:0] op_data,
  input  logic              len_unlimited,
  input  logic [1:0]        flag_clr,
  input  logic              bus_idle,
  input  logic              eod_seen,
  input  logic              crc_ok,
  input  logic              rx_err,
  input  logic              arb_lost,
  input  logic [CNT_W-1:0]  rx_count,
  output logic              cmd_valid,
  output logic [2:0]        cmd_type,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_done,
  output logic              abort_flag,
  output logic              underflow_flag
);
  localparam logic [CNT_W-1:0] UF_CNT_V = CNT_W'(UF_COUNT);

  typedef enum logic [3:0] {
    S_IDLE, S_SOF, S_BYTE, S_IFR, S_CRC, S_INV, S_BRK, S_GAP, S_LOCK
  } st_e;

  st_e st, st_nx;
  logic              pend_valid;
  logic [2:0]        pend_op;
  logic [LEN_W-1:0]  pend_len;
  logic [DATA_W-1:0] pend_data;
  logic [2:0]        cur_op;
  logic [DATA_W-1:0] cur_data;
  logic inv_req, cancel_req;
  logic take, ifr_go, ifr_abort, err_ev, cancel_wr, in_frame, tx_busy;
  logic [1:0] flag_set, flag_q;

  // Named internal events
  assign cancel_wr = op_wr && (op_code == OP_CANCEL);
  assign in_frame  = (st == S_SOF) || (st == S_BYTE) || (st == S_IFR) || (st == S_GAP);
  assign tx_busy   = cmd_valid || (st == S_GAP);
  assign err_ev    = op_wr && is_msg(op_code) && in_frame &&
                     ((cur_op == OP_IFR3) ||
                      (!len_unlimited && (rx_count == UF_CNT_V) && (op_code == OP_MSG)));

  vpw_txop_pend #(.DATA_W(DATA_W), .LEN_W(LEN_W)) pend_i (
    .clk(clk), .rst_n(rst_n),
    .load(op_wr && (op_code != OP_CANCEL) && !err_ev),
    .load_op(op_code), .load_len(op_len), .load_data(op_data),
    .drop(cancel_wr || err_ev || take),
    .valid(pend_valid), .op(pend_op), .len(pend_len), .data(pend_data)
  );

  vpw_txop_ifr_gate #(.LEN_W(LEN_W), .CNT_W(CNT_W), .LIMITED_MAX(LIMITED_MAX)) gate_i (
    .len(pend_len), .len_unlimited(len_unlimited), .rx_count(rx_count),
    .crc_ok(crc_ok), .rx_err(rx_err), .go(ifr_go)
  );

  always_comb begin
    st_nx     = st;
    take      = 1'b0;
    ifr_abort = 1'b0;
    case (st)
      S_IDLE: if (pend_valid) begin
        if (pend_op == OP_BREAK) begin
          st_nx = S_BRK; take = 1'b1;
        end else if (is_msg(pend_op) && bus_idle) begin
          st_nx = S_SOF; take = 1'b1;
        end else if (is_resp(pend_op) && eod_seen) begin
          take = 1'b1;
          if (ifr_go) st_nx = S_IFR;
          else        ifr_abort = 1'b1;
        end
      end
      S_SOF:  if (cmd_done) st_nx = S_BYTE;
      S_BYTE: if (cmd_done)
        st_nx = inv_req ? S_INV : cancel_req ? S_IDLE :
                ends_with_crc(cur_op) ? S_CRC : S_GAP;
      S_IFR:  if (cmd_done)
        st_nx = inv_req ? S_INV : cancel_req ? S_IDLE :
                (cur_op == OP_IFR3_CRC) ? S_CRC :
                (cur_op == OP_IFR3) ? S_GAP : S_IDLE;
      S_CRC, S_INV, S_BRK: if (cmd_done) st_nx = S_IDLE;
      S_GAP: begin
        if (inv_req)         st_nx = S_INV;
        else if (cancel_req) st_nx = S_IDLE;
        else if (pend_valid && (is_type3(cur_op) ? is_type3(pend_op) : is_msg(pend_op))) begin
          st_nx = S_BYTE; take = 1'b1;
        end else if (pend_valid && (pend_op == OP_BREAK)) begin
          st_nx = S_BRK; take = 1'b1;
        end
      end
      S_LOCK: if (bus_idle) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
    if (arb_lost && tx_busy) begin
      st_nx = S_LOCK;
      take  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cur_op     <= OP_CANCEL;
      cur_data   <= '0;
      inv_req    <= 1'b0;
      cancel_req <= 1'b0;
    end else begin
      st <= st_nx;
      if (take) begin
        cur_op   <= pend_op;
        cur_data <= pend_data;
      end
      if (err_ev)
        inv_req <= 1'b1;
      else if ((st_nx == S_INV) || (st_nx == S_LOCK) || (st_nx == S_IDLE) ||
               (st == S_IDLE) || (st == S_LOCK))
        inv_req <= 1'b0;
      if (cancel_wr && (st != S_IDLE) && (st != S_LOCK))
        cancel_req <= 1'b1;
      else if ((st_nx == S_IDLE) || (st_nx == S_LOCK) || (st == S_IDLE) || (st == S_LOCK))
        cancel_req <= 1'b0;
    end
  end

  assign flag_set = {err_ev, ifr_abort || err_ev};

  vpw_txop_flags #(.N(2)) flags_i (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flag(flag_q)
  );
  assign abort_flag     = flag_q[0];
  assign underflow_flag = flag_q[1];

  always_comb begin
    cmd_valid = 1'b1;
    cmd_data  = '0;
    case (st)
      S_SOF:   cmd_type = CMD_SOF;
      S_BYTE:  begin cmd_type = CMD_BYTE; cmd_data = cur_data; end
      S_IFR:   begin cmd_type = CMD_IFR;  cmd_data = cur_data; end
      S_CRC:   cmd_type = CMD_CRC;
      S_INV:   cmd_type = CMD_INV_CRC;
      S_BRK:   cmd_type = CMD_BREAK;
      default: begin cmd_type = CMD_SOF; cmd_valid = 1'b0; end
    endcase
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done && !arb_lost |=>
      cmd_valid && $stable(cmd_type) && $stable(cmd_data)); // R2
  AST_SOF_THEN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_type == CMD_SOF) && cmd_done && !arb_lost |=>
      cmd_valid && (cmd_type == CMD_BYTE)); // R3
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ifr_abort |=> !cmd_valid && abort_flag); // R5
  AST_UF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    err_ev |=> abort_flag && underflow_flag); // R9
  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost && tx_busy |=> !cmd_valid); // R12
endmodule

// File: tb/vpw_txop_seq_tb_top.sv
`timescale 1ns/1ps
module vpw_txop_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_wr = 0; logic [2:0] op_code = 0; logic [3:0] op_len = 0; logic [7:0] op_data = 0;
  logic len_unlimited = 0; logic [1:0] flag_clr = 0;
  logic bus_idle = 1, eod_seen = 0, crc_ok = 1, rx_err = 0, arb_lost = 0;
  logic [3:0] rx_count = 0;
  logic cmd_valid; logic [2:0] cmd_type; logic [7:0] cmd_data; logic cmd_done = 0;
  logic abort_flag, underflow_flag;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  vpw_txop_seq dut_i (
    .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_code(op_code), .op_len(op_len),
    .op_data(op_data), .len_unlimited(len_unlimited), .flag_clr(flag_clr),
    .bus_idle(bus_idle), .eod_seen(eod_seen), .crc_ok(crc_ok), .rx_err(rx_err),
    .arb_lost(arb_lost), .rx_count(rx_count), .cmd_valid(cmd_valid),
    .cmd_type(cmd_type), .cmd_data(cmd_data), .cmd_done(cmd_done),
    .abort_flag(abort_flag), .underflow_flag(underflow_flag)
  );

  // opcode and command codes, as stated in R1
  localparam logic [2:0] O_CAN = 0, O_BRK = 1, O_MSG = 2, O_MSGC = 3,
                         O_R1 = 4, O_R2 = 5, O_R3 = 6, O_R3C = 7;
  localparam int C_SOF = 0, C_BYTE = 1, C_CRC = 2, C_INV = 3, C_BRK = 4, C_IFR = 5;

  // gate vectors: {unlimited, len[3:0], count[3:0], crc_ok, rx_err, expect_sent}
  localparam logic [11:0] GATE_VEC [9] = '{
    {1'b0, 4'd3,  4'd3,  1'b0, 1'b0, 1'b1},
    {1'b0, 4'd3,  4'd4,  1'b1, 1'b0, 1'b0},
    {1'b0, 4'd11, 4'd11, 1'b1, 1'b0, 1'b1},
    {1'b0, 4'd12, 4'd12, 1'b1, 1'b0, 1'b0},
    {1'b1, 4'd12, 4'd12, 1'b1, 1'b0, 1'b1},
    {1'b1, 4'd15, 4'd15, 1'b1, 1'b0, 1'b1},
    {1'b0, 4'd0,  4'd5,  1'b1, 1'b0, 1'b1},
    {1'b0, 4'd0,  4'd5,  1'b0, 1'b0, 1'b0},
    {1'b0, 4'd0,  4'd5,  1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic wr_op(input logic [2:0] op, input logic [3:0] len, input logic [7:0] d);
    op_wr = 1; op_code = op; op_len = len; op_data = d;
    @(negedge clk);
    op_wr = 0;
  endtask

  task automatic wait_valid(input int maxw);
    for (int w = 0; w < maxw && !cmd_valid; w++) @(negedge clk);
  endtask

  task automatic expect_cmd(input int ty, input int d, input int maxw, input string tag);
    wait_valid(maxw);
    chk(cmd_valid && (int'(cmd_type) == ty), {tag, " type"}, cmd_valid ? int'(cmd_type) : -1, ty);
    chk(int'(cmd_data) == d, {tag, " data"}, int'(cmd_data), d);
    cmd_done = 1;
    @(negedge clk);
    cmd_done = 0;
  endtask

  task automatic expect_quiet(input int n, input string tag);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      if (cmd_valid) seen = 1;
      @(negedge clk);
    end
    chk(!seen, tag, int'(seen), 0);
  endtask

  task automatic pulse_eod();
    eod_seen = 1;
    @(negedge clk);
    eod_seen = 0;
  endtask

  task automatic clr_flags();
    flag_clr = 2'b11;
    @(negedge clk);
    flag_clr = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk(!cmd_valid, "R2 reset cmd_valid", int'(cmd_valid), 0);
    chk(!abort_flag && !underflow_flag, "R2 reset flags", int'({underflow_flag, abort_flag}), 0);

    // R5 R6 R7 gate table
    bus_idle = 0;
    for (int i = 0; i < 9; i++) begin
      logic [11:0] v;
      string tag;
      v = GATE_VEC[i];
      tag = (i < 2) ? "R5 gate" : (i < 6) ? "R6 gate" : "R7 gate";
      len_unlimited = v[11]; rx_count = v[6:3]; crc_ok = v[2]; rx_err = v[1];
      wr_op(O_R1, v[10:7], 8'hA0 + 8'(i));
      chk(!cmd_valid, {tag, " waits eod"}, int'(cmd_valid), 0);
      pulse_eod();
      if (v[0]) begin
        expect_cmd(C_IFR, 'hA0 + i, 0, tag);
        chk(!abort_flag, {tag, " no abort"}, int'(abort_flag), 0);
      end else begin
        chk(!cmd_valid && abort_flag, {tag, " aborted"},
            int'({cmd_valid, abort_flag}), 1);
      end
      clr_flags();
    end
    len_unlimited = 0; rx_count = 0; crc_ok = 1; rx_err = 0;

    // R8 response endings
    wr_op(O_R2, 0, 8'h21); pulse_eod();
    expect_cmd(C_IFR, 'h21, 0, "R8 type2");
    expect_quiet(3, "R8 type2 ends");
    wr_op(O_R3C, 0, 8'h31); pulse_eod();
    expect_cmd(C_IFR, 'h31, 0, "R8 type3crc");
    expect_cmd(C_CRC, 0, 0, "R8 type3crc crc");
    expect_quiet(3, "R8 type3crc ends");
    wr_op(O_R3, 0, 8'h41); pulse_eod();
    expect_cmd(C_IFR, 'h41, 0, "R8 type3 first");
    expect_quiet(2, "R8 type3 open");
    wr_op(O_R3, 0, 8'h42);
    expect_cmd(C_BYTE, 'h42, 2, "R8 type3 cont");
    wr_op(O_R3C, 0, 8'h43);
    expect_cmd(C_BYTE, 'h43, 2, "R8 type3 last");
    expect_cmd(C_CRC, 0, 0, "R8 type3 close");

    // R1 break and idle cancel
    bus_idle = 1;
    wr_op(O_CAN, 0, 0);
    expect_quiet(3, "R1 cancel idle");
    wr_op(O_BRK, 0, 0);
    expect_cmd(C_BRK, 0, 2, "R1 break");
    expect_quiet(3, "R1 break single");

    // R3 R4 message frame
    bus_idle = 0;
    wr_op(O_MSG, 4'd15, 8'h11);
    expect_quiet(3, "R3 waits bus idle");
    bus_idle = 1;
    expect_cmd(C_SOF, 0, 2, "R3 sof");
    expect_cmd(C_BYTE, 'h11, 0, "R3 byte");
    expect_quiet(2, "R3 frame open");
    wr_op(O_MSG, 4'd13, 8'h22);
    expect_cmd(C_BYTE, 'h22, 2, "R4 queued byte");
    wr_op(O_MSGC, 0, 8'h33);
    expect_cmd(C_BYTE, 'h33, 2, "R4 last byte");
    expect_cmd(C_CRC, 0, 0, "R3 crc");
    expect_quiet(3, "R3 frame closed");

    // R2 hold without acknowledge
    wr_op(O_MSGC, 0, 8'h44);
    wait_valid(2);
    begin
      bit held = 1;
      for (int k = 0; k < 3; k++) begin
        if (!cmd_valid || cmd_type != 3'(C_SOF)) held = 0;
        @(negedge clk);
      end
      chk(held && cmd_valid, "R2 hold", int'(held), 1);
    end
    expect_cmd(C_SOF, 0, 0, "R2 sof");
    expect_cmd(C_BYTE, 'h44, 0, "R2 byte");
    expect_cmd(C_CRC, 0, 0, "R2 crc");

    // R10 R11 underflow at count 10
    wr_op(O_MSG, 0, 8'h55);
    expect_cmd(C_SOF, 0, 2, "R10 sof");
    expect_cmd(C_BYTE, 'h55, 0, "R10 byte");
    rx_count = 10;
    wr_op(O_MSG, 0, 8'h66);
    chk(abort_flag && underflow_flag, "R10 flags", int'({underflow_flag, abort_flag}), 3);
    expect_cmd(C_INV, 0, 2, "R10 inverted crc");
    expect_quiet(3, "R10 message discarded");
    rx_count = 0;
    clr_flags();
    wr_op(O_MSG, 0, 8'h77);
    expect_cmd(C_SOF, 0, 2, "R11 new frame sof");
    expect_cmd(C_BYTE, 'h77, 0, "R11 byte");
    len_unlimited = 1; rx_count = 10;
    wr_op(O_MSG, 0, 8'h79);
    expect_cmd(C_BYTE, 'h79, 2, "R10 unlimited byte");
    chk(!abort_flag && !underflow_flag, "R10 unlimited flags", int'({underflow_flag, abort_flag}), 0);
    len_unlimited = 0; rx_count = 0;
    wr_op(O_MSGC, 0, 8'h7A);
    expect_cmd(C_BYTE, 'h7A, 2, "R10 close byte");
    expect_cmd(C_CRC, 0, 0, "R10 close crc");

    // R9 message on open type-3 response
    wr_op(O_R3, 0, 8'h90); pulse_eod();
    wait_valid(2);
    wr_op(O_MSG, 0, 8'h91);
    chk(abort_flag && underflow_flag, "R9 flags", int'({underflow_flag, abort_flag}), 3);
    expect_cmd(C_IFR, 'h90, 0, "R9 ifr");
    expect_cmd(C_INV, 0, 0, "R9 inverted crc");
    expect_quiet(3, "R9 message discarded");
    clr_flags();

    // R12 arbitration loss
    wr_op(O_MSG, 0, 8'hA5);
    expect_cmd(C_SOF, 0, 2, "R12 sof");
    bus_idle = 0; arb_lost = 1;
    @(negedge clk);
    arb_lost = 0;
    chk(!cmd_valid, "R12 withdrawn", int'(cmd_valid), 0);
    wr_op(O_MSG, 0, 8'hA6);
    expect_quiet(3, "R12 locked");
    chk(!abort_flag, "R12 no abort", int'(abort_flag), 0);
    bus_idle = 1;
    expect_cmd(C_SOF, 0, 3, "R12 new sof");
    expect_cmd(C_BYTE, 'hA6, 0, "R12 byte");
    wr_op(O_CAN, 0, 0);
    @(negedge clk);
    wr_op(O_MSG, 0, 8'hA7);
    expect_cmd(C_SOF, 0, 2, "R13 cancel in gap then sof");
    expect_cmd(C_BYTE, 'hA7, 0, "R13 byte");
    wr_op(O_MSGC, 0, 8'hA8);
    expect_cmd(C_BYTE, 'hA8, 2, "R13 close byte");
    expect_cmd(C_CRC, 0, 0, "R13 close crc");

    // R13 cancel in flight and pending
    wr_op(O_MSGC, 0, 8'hB1);
    expect_cmd(C_SOF, 0, 2, "R13 sof");
    wait_valid(1);
    wr_op(O_CAN, 0, 0);
    expect_cmd(C_BYTE, 'hB1, 0, "R13 byte in flight");
    expect_quiet(3, "R13 no crc after cancel");
    bus_idle = 0;
    wr_op(O_MSG, 0, 8'hB2);
    wr_op(O_CAN, 0, 0);
    bus_idle = 1;
    expect_quiet(4, "R13 pending cleared");

    // R14 sticky flags
    bus_idle = 0; rx_count = 4;
    wr_op(O_R1, 4'd5, 8'hC1); pulse_eod();
    chk(abort_flag, "R14 abort set", int'(abort_flag), 1);
    flag_clr = 2'b10; @(negedge clk); flag_clr = 2'b00;
    chk(abort_flag, "R14 other clear ignored", int'(abort_flag), 1);
    repeat (2) @(negedge clk);
    chk(abort_flag, "R14 sticky", int'(abort_flag), 1);
    flag_clr = 2'b01; @(negedge clk); flag_clr = 2'b00;
    chk(!abort_flag, "R14 cleared", int'(abort_flag), 0);

    summary();
    $finish;
  end
endmodule